// File: doc/BRIEF.md
# UART Bit-Rate and Character-Time Generator

This block turns a fixed reference clock into the timing strobes a UART needs. Software programs three small configuration registers through a write-only port: a frame-format register, a 16-bit integer rate divisor and a fractional trim register. From the divisor pair the block derives a sub-bit strobe that fires 16 times per bit. It also derives a strobe once per bit period, which lasts 16·(DIV+1)+FRAC reference clocks. The fractional clocks are shared out evenly among the 16 sub-bit intervals instead of being bunched together.

The frame-format register is decoded into the data length, the stop-bit count and the parity settings. These leave the block as static outputs for a serializer and a deserializer elsewhere. A third strobe marks every character time, meaning (data + stop + start) bit periods. A receive-timeout counter downstream uses it. Before a nonzero divisor is written, no bit timing exists, and the character strobe falls back to a fixed default period. That period is ten bit times at 9600 bit/s, which is 25000 clocks at 24 MHz.

A small state machine sequences the block. ST_SYNC is a one-cycle restart state in which all counters are reloaded. It is entered out of reset and after every accepted configuration write, from any state. From ST_SYNC the machine moves to ST_RUN when the divisor is nonzero, and to ST_UNCFG when the divisor is zero. ST_RUN produces the rate-derived strobes. ST_UNCFG produces only the default character strobe. ST_RUN and ST_UNCFG hold until the next write.

Top module: `uart_baud_frame_timer`

## Requirements
- R1: In ST_RUN, every sub-bit strobe interval is DIV+1 or DIV+2 clocks. Exactly FRAC of each 16 intervals per bit are the longer kind, the first interval after a bit strobe is never long, and no two long intervals are adjacent.
- R2: The bit strobe fires together with every 16th sub-bit strobe, so bit strobes are exactly 16·(DIV+1)+FRAC clocks apart.
- R3: While the divisor register (address 1, bits [15:0]) holds zero, neither the sub-bit strobe nor the bit strobe ever fires.
- R4: Only bits [2:0] of a write to the fractional register (address 2) are kept, and the upper bits have no effect on timing.
- R5: The data length output equals bits [1:0] of the frame-format register (address 0) plus 5. After reset it reads 5.
- R6: Frame-format bit 2 set selects two stop bits, and bit 2 clear selects one. The stop count enters the character length.
- R7: Frame-format bit 5 enables parity. When parity is enabled, bit 3 reports even parity (1) or odd parity (0), and bit 4 reports forced parity. When parity is disabled, both outputs read 0. Bit 6 is reported as the infrared flag.
- R8: In ST_RUN, the character strobe fires on the bit strobe that ends each group of (data + stop + 1) bits. The first such group starts at the restart.
- R9: In ST_UNCFG, the character strobe fires every 25000 clocks, and the first one comes 25000 cycles after ST_SYNC.
- R10: A write to address 0, 1 or 2 puts the block in ST_SYNC for the next cycle, with no strobes in that cycle. The first bit strobe follows one full bit period later. A strobe due in the cycle of the write itself is still emitted.
- R11: A write to address 3 changes no output and does not disturb the strobe phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 frame format, 1 divisor, 2 fraction |
| cfg_wdata | input | 16 | Write data |
| os_tick | output | 1 | Sub-bit strobe, 16 per bit |
| bit_tick | output | 1 | One strobe per bit period |
| char_tick | output | 1 | One strobe per character time |
| data_bits | output | 4 | Decoded data length, 5 to 8 |
| two_stop | output | 1 | Two stop bits selected |
| parity_en | output | 1 | Parity enabled |
| parity_even | output | 1 | Even parity (0 when parity is off) |
| parity_forced | output | 1 | Forced parity (0 when parity is off) |
| ir_mode | output | 1 | Infrared flag |

## Verification
The sharpest collision is a configuration write that lands in the very cycle in which a bit strobe fires. The strobe must still appear, and the restart must then take the next cycle without producing a second strobe. The bench provokes this by synchronising to a bit strobe and issuing the write in that same cycle. It judges the result by checking for silence in the ST_SYNC cycle and by measuring exactly one bit period to the next bit strobe. A second case lets a bit strobe coincide with the character strobe. The bench requires both to be high in the same sampled cycle.

// File: rtl/utm_pkg.sv
package utm_pkg;

    typedef enum logic [1:0] {
        ST_SYNC  = 2'd0,
        ST_UNCFG = 2'd1,
        ST_RUN   = 2'd2
    } utm_state_e;

    localparam logic [1:0] ADDR_FRAME = 2'd0;
    localparam logic [1:0] ADDR_IDIV  = 2'd1;
    localparam logic [1:0] ADDR_FDIV  = 2'd2;

    typedef struct packed {
        logic [3:0] data_bits;
        logic       two_stop;
        logic       par_en;
        logic       par_even;
        logic       par_forced;
        logic       ir;
    } frame_fmt_t;

endpackage

// File: rtl/utm_cfg_regs.sv
module utm_cfg_regs
    import utm_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 3,
    parameter int WD_W   = 16,
    parameter int FMT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [WD_W-1:0]   wdata,
    output logic [DIV_W-1:0]  div_q,
    output logic [FRAC_W-1:0] frac_q,
    output logic [FMT_W-1:0]  fmt_q,
    output logic              cfg_hit
);

    always_comb begin
        cfg_hit = we && ((addr == ADDR_FRAME) || (addr == ADDR_IDIV) || (addr == ADDR_FDIV));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            frac_q <= '0;
            fmt_q  <= '0;
        end else if (we) begin
            unique case (addr)
                ADDR_FRAME: fmt_q  <= wdata[FMT_W-1:0];
                ADDR_IDIV:  div_q  <= wdata[DIV_W-1:0];
                ADDR_FDIV:  frac_q <= wdata[FRAC_W-1:0];
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/utm_frame_dec.sv
module utm_frame_dec
    import utm_pkg::*;
#(
    parameter int FMT_W   = 8,
    parameter int CHAR_W  = 4,
    parameter int MIN_LEN = 5
) (
    input  logic [FMT_W-1:0]  fmt,
    output frame_fmt_t        dec,
    output logic [CHAR_W-1:0] char_bits
);

    localparam int BIT_LEN_LO = 0;
    localparam int BIT_STOP   = 2;
    localparam int BIT_EVEN   = 3;
    localparam int BIT_FORCE  = 4;
    localparam int BIT_PAR    = 5;
    localparam int BIT_IR     = 6;

    always_comb begin
        dec.data_bits  = 4'(fmt[BIT_LEN_LO +: 2]) + 4'(MIN_LEN);
        dec.two_stop   = fmt[BIT_STOP];
        dec.par_en     = fmt[BIT_PAR];
        dec.par_even   = fmt[BIT_PAR] & fmt[BIT_EVEN];
        dec.par_forced = fmt[BIT_PAR] & fmt[BIT_FORCE];
        dec.ir         = fmt[BIT_IR];
        char_bits      = CHAR_W'(dec.data_bits) + (fmt[BIT_STOP] ? CHAR_W'(2) : CHAR_W'(1))
                         + CHAR_W'(1);
    end

endmodule

// File: rtl/utm_bit_timer.sv
module utm_bit_timer #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 3,
    parameter int SUB_N  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic [DIV_W-1:0]  div,
    input  logic [FRAC_W-1:0] frac,
    output logic              os_tick,
    output logic              bit_tick
);

    localparam int IDX_W = $clog2(SUB_N);
    localparam int CNT_W = DIV_W + 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SUB_N - 1);

    logic [CNT_W-1:0] sub_cnt_q;
    logic [IDX_W-1:0] acc_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W:0]   acc_nx;
    logic [CNT_W-1:0] reload_m1;

    always_comb begin
        acc_nx    = {1'b0, acc_q} + (IDX_W + 1)'(frac);
        reload_m1 = CNT_W'(div) + CNT_W'(acc_nx[IDX_W]);
        os_tick   = run && (sub_cnt_q == '0);
        bit_tick  = os_tick && (idx_q == IDX_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_cnt_q <= '0;
            acc_q     <= '0;
            idx_q     <= '0;
        end else if (load) begin
            sub_cnt_q <= CNT_W'(div);
            acc_q     <= IDX_W'(frac);
            idx_q     <= '0;
        end else if (run) begin
            if (sub_cnt_q == '0) begin
                sub_cnt_q <= reload_m1;
                acc_q     <= acc_nx[IDX_W-1:0];
                idx_q     <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
            end else begin
                sub_cnt_q <= sub_cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/utm_char_timer.sv
module utm_char_timer #(
    parameter int CHAR_W   = 4,
    parameter int DEF_CLKS = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic              uncfg,
    input  logic              bit_tick,
    input  logic [CHAR_W-1:0] char_bits,
    output logic              char_tick
);

    localparam int DEF_W = $clog2(DEF_CLKS);
    localparam logic [DEF_W-1:0] DEF_M1 = DEF_W'(DEF_CLKS - 1);

    logic [CHAR_W-1:0] bit_cnt_q;
    logic [DEF_W-1:0]  def_cnt_q;
    logic              last_bit;

    always_comb begin
        last_bit  = (bit_cnt_q == char_bits - 1'b1);
        char_tick = (run && bit_tick && last_bit) || (uncfg && (def_cnt_q == '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            def_cnt_q <= DEF_M1;
        end else if (load) begin
            bit_cnt_q <= '0;
            def_cnt_q <= DEF_M1;
        end else begin
            if (run && bit_tick) begin
                bit_cnt_q <= last_bit ? '0 : bit_cnt_q + 1'b1;
            end
            if (uncfg) begin
                def_cnt_q <= (def_cnt_q == '0) ? DEF_M1 : def_cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_baud_frame_timer.sv
module uart_baud_frame_timer
    import utm_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int FRAC_W   = 3,
    parameter int SUB_N    = 16,
    parameter int REF_HZ   = 24000000,
    parameter int DEF_BAUD = 9600,
    parameter int DEF_BITS = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [15:0] cfg_wdata,
    output logic        os_tick,
    output logic        bit_tick,
    output logic        char_tick,
    output logic [3:0]  data_bits,
    output logic        two_stop,
    output logic        parity_en,
    output logic        parity_even,
    output logic        parity_forced,
    output logic        ir_mode
);

    localparam int FMT_W    = 8;
    localparam int CHAR_W   = 4;
    localparam int DEF_CLKS = (REF_HZ / DEF_BAUD) * DEF_BITS;

    logic [DIV_W-1:0]  div_q;
    logic [FRAC_W-1:0] frac_q;
    logic [FMT_W-1:0]  fmt_q;
    logic              cfg_hit;
    frame_fmt_t        fmt_dec;
    logic [CHAR_W-1:0] char_bits;
    utm_state_e        state_q, state_nx;
    logic              st_load, st_run, st_uncfg;

    utm_cfg_regs #(
        .DIV_W (DIV_W),
        .FRAC_W(FRAC_W),
        .WD_W  (16),
        .FMT_W (FMT_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .div_q  (div_q),
        .frac_q (frac_q),
        .fmt_q  (fmt_q),
        .cfg_hit(cfg_hit)
    );

    utm_frame_dec #(
        .FMT_W  (FMT_W),
        .CHAR_W (CHAR_W),
        .MIN_LEN(5)
    ) u_dec (
        .fmt      (fmt_q),
        .dec      (fmt_dec),
        .char_bits(char_bits)
    );

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_SYNC:  state_nx = (div_q != '0) ? ST_RUN : ST_UNCFG;
            ST_UNCFG: state_nx = ST_UNCFG;
            ST_RUN:   state_nx = ST_RUN;
            default:  state_nx = ST_SYNC;
        endcase
        if (cfg_hit) begin
            state_nx = ST_SYNC;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SYNC;
        end else begin
            state_q <= state_nx;
        end
    end

    // State decode to counter controls
    always_comb begin
        st_load  = 1'b0;
        st_run   = 1'b0;
        st_uncfg = 1'b0;
        unique case (state_q)
            ST_SYNC:  st_load  = 1'b1;
            ST_UNCFG: st_uncfg = 1'b1;
            ST_RUN:   st_run   = 1'b1;
            default:  st_load  = 1'b1;
        endcase
    end

    utm_bit_timer #(
        .DIV_W (DIV_W),
        .FRAC_W(FRAC_W),
        .SUB_N (SUB_N)
    ) u_bit (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (st_load),
        .run     (st_run),
        .div     (div_q),
        .frac    (frac_q),
        .os_tick (os_tick),
        .bit_tick(bit_tick)
    );

    utm_char_timer #(
        .CHAR_W  (CHAR_W),
        .DEF_CLKS(DEF_CLKS)
    ) u_char (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (st_load),
        .run      (st_run),
        .uncfg    (st_uncfg),
        .bit_tick (bit_tick),
        .char_bits(char_bits),
        .char_tick(char_tick)
    );

    always_comb begin
        data_bits     = fmt_dec.data_bits;
        two_stop      = fmt_dec.two_stop;
        parity_en     = fmt_dec.par_en;
        parity_even   = fmt_dec.par_even;
        parity_forced = fmt_dec.par_forced;
        ir_mode       = fmt_dec.ir;
    end

endmodule

// File: rtl/utm_chk.sv
module utm_chk #(
    parameter int DIV_W = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [1:0]  cfg_addr,
    input logic [15:0] cfg_wdata,
    input logic        os_tick,
    input logic        bit_tick,
    input logic [3:0]  data_bits,
    input logic        two_stop
);

    logic [DIV_W-1:0] div_sh;
    logic [2:0]       frac_sh;
    logic [DIV_W+1:0] gap_q;
    logic             gap_ok_q;
    logic             wr_hit;

    always_comb begin
        wr_hit = cfg_we && (cfg_addr != 2'd3);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_sh   <= '0;
            frac_sh  <= '0;
            gap_q    <= '0;
            gap_ok_q <= 1'b0;
        end else begin
            if (cfg_we && cfg_addr == 2'd1) div_sh  <= cfg_wdata[DIV_W-1:0];
            if (cfg_we && cfg_addr == 2'd2) frac_sh <= cfg_wdata[2:0];
            if (wr_hit) begin
                gap_ok_q <= 1'b0;
                gap_q    <= '0;
            end else if (os_tick) begin
                gap_ok_q <= 1'b1;
                gap_q    <= 1;
            end else begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    AST_SUB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick && gap_ok_q) |->
            ((gap_q == (DIV_W+2)'(div_sh) + 1) ||
             ((frac_sh != 3'd0) && (gap_q == (DIV_W+2)'(div_sh) + 2)))); // R1

    AST_NO_TICK_ZERO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sh == '0) |-> (!os_tick && !bit_tick)); // R3

    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_hit) |-> !os_tick); // R10

    AST_DATA_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we && cfg_addr == 2'd0) |->
            (data_bits == 4'($past(cfg_wdata[1:0])) + 4'd5)); // R5

    AST_STOP_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we && cfg_addr == 2'd0) |-> (two_stop == $past(cfg_wdata[2]))); // R6

endmodule

bind uart_baud_frame_timer utm_chk #(.DIV_W(DIV_W)) u_utm_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .os_tick  (os_tick),
    .bit_tick (bit_tick),
    .data_bits(data_bits),
    .two_stop (two_stop)
);

// File: tb/uart_baud_frame_timer_bench.sv
module uart_baud_frame_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        os_tick, bit_tick, char_tick;
    logic [3:0]  data_bits;
    logic        two_stop, parity_en, parity_even, parity_forced, ir_mode;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    localparam int DEF_CHAR = 25000;

    always #10 clk = ~clk;

    uart_baud_frame_timer u_uart_baud_frame_timer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .os_tick(os_tick), .bit_tick(bit_tick),
        .char_tick(char_tick), .data_bits(data_bits), .two_stop(two_stop),
        .parity_en(parity_en), .parity_even(parity_even),
        .parity_forced(parity_forced), .ir_mode(ir_mode)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge (ST_SYNC cycle)
    task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // cycles until the selected strobe is seen (0 os, 1 bit, 2 char); -1 if never
    task automatic wait_sig(input int which, output int n);
        bit seen = 0;
        n = 0;
        while (!seen && n < 40000) begin
            @(negedge clk);
            n++;
            case (which)
                0: seen = os_tick;
                1: seen = bit_tick;
                default: seen = char_tick;
            endcase
        end
        if (!seen) n = -1;
    endtask

    task automatic t_reset;
        chk("R5 reset data_bits", data_bits, 5);
        chk("R6 reset two_stop", two_stop, 0);
        chk("R7 reset parity_en", parity_en, 0);
        chk("R3 reset os_tick", os_tick, 0);
    endtask

    task automatic t_unconfigured;
        int cnt = 0;
        int n;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (os_tick || bit_tick) cnt++;
        end
        chk("R3 no strobes before divisor", cnt, 0);
        wait_sig(2, n);
        wait_sig(2, n);
        chk("R9 default char period", n, DEF_CHAR);
    endtask

    task automatic t_rate(input int dv, input logic [15:0] fw, input int fr);
        int n, p, longs, adj, prev_long, sum;
        p = 16 * (dv + 1) + fr;
        cfg_write(2'd1, 16'(dv));
        cfg_write(2'd2, fw);
        chk("R10 first bit after restart", os_tick, 0);
        wait_sig(1, n);
        chk("R10 restart to first bit", n, p);
        longs = 0; adj = 0; prev_long = 0; sum = 0;
        for (int k = 0; k < 16; k++) begin
            wait_sig(0, n);
            sum += n;
            if (n != dv + 1 && n != dv + 2) chk("R1 sub interval length", n, dv + 1);
            if (n == dv + 2) begin
                longs++;
                if (prev_long) adj++;
                if (k == 0) chk("R1 first sub interval short", n, dv + 1);
            end
            prev_long = (n == dv + 2);
        end
        chk("R2 bit strobe on 16th sub strobe", bit_tick, 1);
        chk("R2 bit period", sum, p);
        chk("R4 long intervals equal fraction", longs, fr);
        chk("R1 long intervals not adjacent", adj, 0);
    endtask

    task automatic t_decode(input logic [7:0] f, input int db, input int ts,
                            input int pe, input int ev, input int fo, input int ir);
        cfg_write(2'd0, {8'h00, f});
        chk("R5 data length", data_bits, db);
        chk("R6 stop select", two_stop, ts);
        chk("R7 parity enable", parity_en, pe);
        chk("R7 parity even", parity_even, ev);
        chk("R7 parity forced", parity_forced, fo);
        chk("R7 infrared flag", ir_mode, ir);
    endtask

    task automatic t_char(input logic [7:0] f, input int bits, input int p);
        int n;
        cfg_write(2'd0, {8'h00, f});
        wait_sig(2, n);
        chk("R8 first char after restart", n, bits * p);
        chk("R8 char on bit strobe", bit_tick, 1);
        wait_sig(2, n);
        chk("R6 R8 char period", n, bits * p);
    endtask

    task automatic t_coincide(input int p);
        int n;
        wait_sig(1, n);
        chk("R10 strobe in write cycle", bit_tick, 1);
        cfg_write(2'd2, 16'd7);
        chk("R10 quiet sync cycle", os_tick, 0);
        wait_sig(1, n);
        chk("R10 bit period after coincident write", n, p);
    endtask

    task automatic t_ignored(input int p);
        int n;
        logic [3:0] db;
        db = data_bits;
        wait_sig(1, n);
        cfg_write(2'd3, 16'hFFFF);
        wait_sig(1, n);
        chk("R11 phase kept after address 3", n, p - 1);
        chk("R11 data length kept", data_bits, db);
    endtask

    task automatic t_div_zero;
        int cnt = 0;
        int n;
        cfg_write(2'd1, 16'd0);
        wait_sig(2, n);
        chk("R9 default char after zero divisor", n, DEF_CHAR);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (os_tick || bit_tick) cnt++;
        end
        chk("R3 no strobes with zero divisor", cnt, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unconfigured();
        t_rate(2, 16'd5, 5);
        t_rate(4, 16'hFFF8, 0);
        t_rate(1, 16'd7, 7);
        t_decode(8'h3F, 8, 1, 1, 1, 1, 0);
        t_decode(8'h63, 8, 0, 1, 0, 0, 1);
        t_decode(8'h1B, 8, 0, 0, 0, 0, 0);
        t_decode(8'h05, 6, 1, 0, 0, 0, 0);
        t_char(8'h03, 10, 39);
        t_char(8'h04, 8, 39);
        t_char(8'h27, 11, 39);
        t_coincide(39);
        t_ignored(39);
        t_div_zero();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule